// File: doc/BRIEF.md
# CPU Clock Source and Divider Controller

This block decides which clock paces a small microcontroller's CPU and at what rate. It receives a fast main-oscillator tick and two slow subsystem ticks, all as single-cycle enable pulses in one fast system clock domain. A control register written by software sets the main-clock divide ratio, asks for the CPU to run from the first subsystem clock, and can stop the main oscillator. The block produces the CPU clock enable, the main oscillator enable and the peripheral clock enables.

The block refuses illegal sequences. A request to move the CPU to the slow clock is dropped unless a fast divider setting is stored. A request to stop the main oscillator is dropped unless the slow clock already drives the CPU. A return to the main clock is held off until the restarted oscillator has produced a set number of ticks. The source changes over only in a cycle in which neither candidate enable pulses. A HALT request gates the CPU enable, and the peripheral enables keep running. An interrupt request ends HALT.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: After reset `ctrl_o` reads 0x04, `src_sub_o` and `halted_o` are 0, and the CPU enable fires once every 8 main ticks.
- R2: While the main clock drives the CPU, the CPU enable fires once every 2, 4 or 8 main ticks for `ctrl_o[2:0]` = 0, 1 or 2. For 3 (reserved) or any value with bit 2 set, it fires once every 8 main ticks.
- R3: Writing bit 4 = 1 while bit 4 is stored as 0 sets it only if the stored `ctrl_o[2:0]` is 0, 1 or 2. Otherwise bit 4 stays 0 and the CPU stays on the main clock.
- R4: While `src_sub_o` is 1 and the block is not halted, `cpu_en_o` equals `sub1_tick_i`.
- R5: A write of bit 6 = 1 sets it only if `src_sub_o` is 1 and the new bit 4 is 1. Otherwise the write is ignored. While bit 6 is 1, `main_osc_en_o` is 0 and `per_main_en_o` stays low.
- R6: After the oscillator restarts, a write that clears bit 4 is ignored until STAB_CYCLES main ticks have arrived. After that, such a write takes effect.
- R7: `src_sub_o` reports the source actually in use. It changes to follow bit 4 only in a cycle in which neither the divided main pulse nor `sub1_tick_i` is high.
- R8: A pulse on `halt_req_i` sets `halted_o` on the next edge, in either source mode. While `halted_o` is 1, `cpu_en_o` is 0.
- R9: `irq_i` clears `halted_o` on the next edge. The CPU enable then resumes with the next tick of the selected source.
- R10: `per_sub1_en_o` and `per_sub2_en_o` follow their ticks whether or not the block is halted. `sub2_tick_i` never produces `cpu_en_o`.
- R11: `main_osc_en_o` is 0 while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| main_tick_i | input | 1 | main oscillator cycle pulse |
| sub1_tick_i | input | 1 | subsystem clock 1 cycle pulse |
| sub2_tick_i | input | 1 | subsystem clock 2 cycle pulse |
| wr_en_i | input | 1 | control register write strobe |
| wr_data_i | input | 8 | control register write data |
| halt_req_i | input | 1 | CPU requests HALT |
| irq_i | input | 1 | enabled interrupt request |
| ctrl_o | output | 8 | control register contents |
| src_sub_o | output | 1 | 1 while subsystem clock 1 drives the CPU |
| halted_o | output | 1 | HALT active |
| main_osc_en_o | output | 1 | main oscillator run enable |
| cpu_en_o | output | 1 | CPU clock enable |
| per_main_en_o | output | 1 | main-clock peripheral enable |
| per_sub1_en_o | output | 1 | subsystem clock 1 peripheral enable |
| per_sub2_en_o | output | 1 | subsystem clock 2 peripheral enable |

## Verification
Some rules are checked by the assertions on every cycle. Bit 4 rises only from a fast divider setting. Bit 6 rises only while the slow source is in use. Bit 4 falls only once the oscillator is stable. The source flips only in a quiet cycle. HALT is entered only on request and left on an interrupt. The oscillator stays off only while the slow clock is in use.

Other behaviour only the bench scenarios can show, by counting enables over fixed windows: the exact divide ratios for all eight divider codes, the dropped switch and stop writes, the early switch-back that is held off, the peripheral enables that keep running during HALT, and the return to the defaults after a reset taken from the stopped state.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int CTRL_W   = 8;
  localparam int DIV_W    = 3;
  localparam int SUB_BIT  = 4;
  localparam int STOP_BIT = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST   = 8'h04;
  localparam logic [DIV_W-1:0]  SUB_OK_MAX = 3'd2;

  // mask of divider counter bits that must all be set for a CPU pulse
  function automatic logic [DIV_W-1:0] div_mask(input logic [DIV_W-1:0] sel);
    logic [DIV_W-1:0] m;
    case (sel)
      3'd0:    m = 3'b001;
      3'd1:    m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ccu_ctrl_reg.sv
module ccu_ctrl_reg
  import ccu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              src_sub_i,
  input  logic              osc_stable_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic              new_sub, new_stop;
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    if (ctrl_o[SUB_BIT]) new_sub = wr_data_i[SUB_BIT] | ~osc_stable_i;
    else                 new_sub = wr_data_i[SUB_BIT] & (ctrl_o[DIV_W-1:0] <= SUB_OK_MAX);
    new_stop = wr_data_i[STOP_BIT] & src_sub_i & new_sub;
    ctrl_d = wr_data_i;
    ctrl_d[SUB_BIT]  = new_sub;
    ctrl_d[STOP_BIT] = new_stop;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_o <= CTRL_RST;
    else if (wr_en_i) ctrl_o <= ctrl_d;

  AST_SUB_FROM_FAST_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[SUB_BIT]) |-> ($past(ctrl_o[DIV_W-1:0]) <= SUB_OK_MAX)); // R3
  AST_STOP_ONLY_ON_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[STOP_BIT]) |-> $past(src_sub_i)); // R5
  AST_LEAVE_SUB_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[SUB_BIT]) |-> $past(osc_stable_i)); // R6
endmodule

// File: rtl/ccu_osc_stab.sv
module ccu_osc_stab #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic main_tick_i,
  output logic stable_o
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STAB_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                            cnt_q <= '0;
    else if (!osc_en_i)                     cnt_q <= '0;
    else if (main_tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;

  assign stable_o = (cnt_q == LIMIT);

  AST_STABLE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_o) |-> ($past(main_tick_i) && $past(osc_en_i))); // R6
endmodule

// File: rtl/ccu_main_div.sv
module ccu_main_div
  import ccu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] sel_i,
  output logic             pulse_o
);
  logic [DIV_W-1:0] cnt_q, mask;

  assign mask = div_mask(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;

  assign pulse_o = tick_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
  import ccu_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              main_tick_i,
  input  logic              sub1_tick_i,
  input  logic              sub2_tick_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              halt_req_i,
  input  logic              irq_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              src_sub_o,
  output logic              halted_o,
  output logic              main_osc_en_o,
  output logic              cpu_en_o,
  output logic              per_main_en_o,
  output logic              per_sub1_en_o,
  output logic              per_sub2_en_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic osc_run, main_vtick, main_pulse, osc_stable;
  logic src_sub_q, halted_q, quiet;

  assign osc_run    = rst_ni & ~ctrl_q[STOP_BIT];
  assign main_vtick = main_tick_i & osc_run;

  ccu_ctrl_reg i_ctrl_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .src_sub_i(src_sub_q), .osc_stable_i(osc_stable), .ctrl_o(ctrl_q)
  );

  ccu_osc_stab #(.STAB_CYCLES(STAB_CYCLES)) i_osc_stab (
    .clk_i, .rst_ni, .osc_en_i(osc_run), .main_tick_i(main_vtick), .stable_o(osc_stable)
  );

  ccu_main_div i_main_div (
    .clk_i, .rst_ni, .tick_i(main_vtick), .sel_i(ctrl_q[DIV_W-1:0]), .pulse_o(main_pulse)
  );

  // handover only where both candidate enables are low
  assign quiet = ~main_pulse & ~sub1_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                  src_sub_q <= 1'b0;
    else if (quiet && src_sub_q != ctrl_q[SUB_BIT]) src_sub_q <= ctrl_q[SUB_BIT];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         halted_q <= 1'b0;
    else if (irq_i)      halted_q <= 1'b0;
    else if (halt_req_i) halted_q <= 1'b1;

  assign cpu_en_o      = ~halted_q & (src_sub_q ? sub1_tick_i : main_pulse);
  assign ctrl_o        = ctrl_q;
  assign src_sub_o     = src_sub_q;
  assign halted_o      = halted_q;
  assign main_osc_en_o = osc_run;
  assign per_main_en_o = main_vtick;
  assign per_sub1_en_o = sub1_tick_i;
  assign per_sub2_en_o = sub2_tick_i;

  AST_SWITCH_IN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sub_q != $past(src_sub_q)) |-> (!$past(main_pulse) && !$past(sub1_tick_i))); // R7
  AST_OSC_OFF_ON_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_osc_en_o |-> src_sub_q); // R5
  AST_HALT_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_q) |-> $past(halt_req_i)); // R8
  AST_HALT_EXIT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && irq_i) |=> !halted_q); // R9
endmodule

// File: tb/test_cpu_clk_ctrl.sv
module test_cpu_clk_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic main_tick_i = 1'b0, sub1_tick_i = 1'b0, sub2_tick_i = 1'b0;
  logic wr_en_i = 1'b0, halt_req_i = 1'b0, irq_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] ctrl_o;
  logic src_sub_o, halted_o, main_osc_en_o, cpu_en_o;
  logic per_main_en_o, per_sub1_en_o, per_sub2_en_o;

  int n_cmp = 0, n_mis = 0, cyc = 0;
  int cpu_cnt = 0, pm_cnt = 0, s1_cnt = 0, s2_cnt = 0;
  bit s1_on = 1'b1, done = 1'b0;

  always #10 clk = ~clk;

  cpu_clk_ctrl #(.STAB_CYCLES(16)) i_cpu_clk_ctrl (
    .clk_i(clk), .rst_ni, .main_tick_i, .sub1_tick_i, .sub2_tick_i,
    .wr_en_i, .wr_data_i, .halt_req_i, .irq_i, .ctrl_o, .src_sub_o,
    .halted_o, .main_osc_en_o, .cpu_en_o, .per_main_en_o,
    .per_sub1_en_o, .per_sub2_en_o
  );

  // tick sources: main every cycle, sub1 every 16, sub2 every 4
  always @(negedge clk) begin
    cyc         <= cyc + 1;
    main_tick_i <= 1'b1;
    sub1_tick_i <= s1_on && (cyc % 16 == 0);
    sub2_tick_i <= (cyc % 4 == 0);
  end

  always @(negedge clk) begin
    if (cpu_en_o)      cpu_cnt++;
    if (per_main_en_o) pm_cnt++;
    if (per_sub1_en_o) s1_cnt++;
    if (per_sub2_en_o) s2_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en_i <= 1'b1; wr_data_i <= v;
    @(negedge clk); wr_en_i <= 1'b0;
    #2;
  endtask

  task automatic pulse(input bit is_irq);
    @(negedge clk);
    if (is_irq) irq_i <= 1'b1; else halt_req_i <= 1'b1;
    @(negedge clk); irq_i <= 1'b0; halt_req_i <= 1'b0;
    #2;
  endtask

  task automatic measure(input int n);
    @(negedge clk); #2;
    cpu_cnt = 0; pm_cnt = 0; s1_cnt = 0; s2_cnt = 0;
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R11 osc off in reset", main_osc_en_o, 0);
    chk("R1 src after reset", src_sub_o, 0);
    chk("R1 halted after reset", halted_o, 0);
    chk("R1 ctrl reset value", ctrl_o, 8'h04);
    @(negedge clk); rst_ni <= 1'b1;
    idle(4);
    measure(64);
    chk("R1 default divide by 8", cpu_cnt, 8);

    // R2 / R3 / R4 / R7 sweep over every divider code
    for (int d = 0; d < 8; d++) begin
      wr(8'(d));
      idle(4);
      measure(64);
      chk("R2 main divide", cpu_cnt, 64 / ((d >= 3) ? 8 : (2 << d)));
      wr(8'(d) | 8'h10);
      idle(20);
      chk("R3 switch accepted bit", ctrl_o[4], (d <= 2) ? 1 : 0);
      chk("R7 status source", src_sub_o, (d <= 2) ? 1 : 0);
      if (d <= 2) begin
        measure(64);
        chk("R4 cpu on sub1", cpu_cnt, 4);
        wr(8'(d));
        idle(20);
        chk("R7 back to main", src_sub_o, 0);
      end else begin
        measure(64);
        chk("R3 stays on main", cpu_cnt, 8);
      end
    end

    // R8 / R9 halt on main clock
    wr(8'h00);
    pulse(1'b0);
    chk("R8 halted main", halted_o, 1);
    measure(64);
    chk("R8 cpu gated main", cpu_cnt, 0);
    pulse(1'b1);
    chk("R9 halt cleared", halted_o, 0);
    measure(64);
    chk("R9 cpu resumes main", cpu_cnt, 32);

    // R5 stop ignored on main
    wr(8'h40);
    idle(4);
    chk("R5 stop ignored osc", main_osc_en_o, 1);
    chk("R5 stop ignored bit", ctrl_o[6], 0);
    measure(64);
    chk("R5 main periph runs", pm_cnt, 64);

    // R5 stop accepted on sub1
    wr(8'h10);
    idle(20);
    chk("R7 on sub1", src_sub_o, 1);
    wr(8'h50);
    idle(4);
    chk("R5 osc stopped", main_osc_en_o, 0);
    measure(64);
    chk("R5 main periph silent", pm_cnt, 0);
    chk("R4 cpu on sub1 stopped", cpu_cnt, 4);

    // R8 / R9 / R10 halt on sub1 with oscillator off
    pulse(1'b0);
    chk("R8 halted sub", halted_o, 1);
    measure(64);
    chk("R8 cpu gated sub", cpu_cnt, 0);
    chk("R10 sub1 periph in halt", s1_cnt, 4);
    chk("R10 sub2 periph in halt", s2_cnt, 16);
    pulse(1'b1);
    chk("R9 halt cleared sub", halted_o, 0);
    measure(64);
    chk("R9 cpu resumes sub", cpu_cnt, 4);

    // R10 sub2 never reaches the CPU
    s1_on = 1'b0;
    measure(64);
    chk("R10 no cpu from sub2", cpu_cnt, 0);
    chk("R10 sub2 periph", s2_cnt, 16);
    s1_on = 1'b1;

    // R6 early switch back refused, later accepted
    wr(8'h10);
    chk("R6 osc restarted", main_osc_en_o, 1);
    idle(1);
    wr(8'h00);
    idle(20);
    chk("R6 early return refused", src_sub_o, 1);
    chk("R6 sub bit kept", ctrl_o[4], 1);
    wr(8'h00);
    idle(20);
    chk("R6 return after settle", src_sub_o, 0);
    measure(64);
    chk("R2 main divide after return", cpu_cnt, 32);

    // R11 / R1 reset taken from stopped state
    wr(8'h10);
    idle(20);
    wr(8'h50);
    idle(4);
    @(negedge clk); rst_ni <= 1'b0;
    idle(3);
    chk("R11 osc off in reset again", main_osc_en_o, 0);
    chk("R1 src reset again", src_sub_o, 0);
    chk("R1 ctrl reset again", ctrl_o, 8'h04);
    @(negedge clk); rst_ni <= 1'b1;
    idle(4);
    chk("R11 osc on after reset", main_osc_en_o, 1);
    measure(64);
    chk("R1 default divide again", cpu_cnt, 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule